// File: doc/BRIEF.md
# SPI Serial SRAM Target

This block is the target side of an SPI link that fronts a byte-wide on-chip RAM. A host addresses it the way it would address a small serial SRAM: it lowers chip select, sends an 8-bit instruction, then either a 16-bit address followed by data, or a single status byte. All serial inputs are oversampled by a fast system clock through two-flop synchronizers. Clock edges are found from the synchronized samples, so the system clock must run at least four times faster than SCK. Serial output is presented as a data bit plus an output-enable, and the pad driver is left to the surrounding chip.

A three-bit status register sets the access mode and the pause feature. The mode field selects one of three behaviours. In single-byte mode one data byte moves per command. In page mode the address advances and wraps inside a 32-byte page. In sequential mode the address advances over the whole array and rolls over at the top. A hold input pauses a transfer partway through and resumes it later at the same point. The status register can switch this pause feature off.

The array size is set by `ADDR_W`, which defaults to 10 bits (1 KB). The address field on the wire is always 16 bits.

Top module: `spi_sram_target`

## Requirements
- R1: After reset, so_oe is low and a status read (opcode 0x05) returns 0x00.
- R2: Bits move MSB first. SI is sampled on SCK rising edges and SO changes after SCK falling edges. Opcode 0x03 reads, 0x02 writes, 0x05 reads the status byte and 0x01 writes it.
- R3: The 16 address bits follow the opcode. Only the low ADDR_W bits select a byte, so all higher bits, including the most significant, are ignored.
- R4: so_oe is high only during the data bits of a READ or status read. It goes high after the first falling SCK edge of that data phase and stays low during the opcode and address bits.
- R5: With status[7:6] = 00 (single-byte mode), one byte is read or written. Later clocks in the same selection write nothing and leave so_oe low.
- R6: With status[7:6] = 10 (page mode), the address advances after each byte. Its low 5 bits wrap from 31 to 0 and the page bits do not change.
- R7: With status[7:6] = 01 (sequential mode), the address advances after each byte and wraps from 2^ADDR_W-1 to 0.
- R8: While cs_n is high, so_oe is low. Raising cs_n aborts any transfer, and the next selection starts with an opcode.
- R9: A status write stores bits 7:6 and bit 0. Bits 5:1 always read as 0. The status byte is laid out as {mode[1:0], 5'b0, hold_disable}.
- R10: Mode 11 behaves like single-byte mode.
- R11: When status bit 0 is 0, hold_n low pauses the transfer. The pause starts while SCK is low, or else at the next SCK fall. While paused, SCK and SI are ignored and so_oe is low. Raising hold_n while SCK is low resumes the transfer at the same bit.
- R12: When status bit 0 is 1, hold_n has no effect.
- R13: An unknown opcode makes the rest of that selection ignored: memory and status do not change and so_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data into target |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out of target |
| so_oe | output | 1 | Output enable for so |

## Verification
The checker assumes the host meets the interface's timing rules. SCK has a half period of several system clocks. SI, cs_n and hold_n change only while SCK is low and stable for a system clock or more, so the synchronized samples never see SCK and SI disagree. The bench drives SCK with a six-clock half period and changes SI, cs_n and hold_n only in the low phase. It raises or lowers hold_n only while SCK is low. Address bookkeeping in the page and sequential properties relies on these orderly edges.

// File: rtl/spi_sram_target.sv
module spi_sram_target #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] S_CMD = 3'd0, S_ADR = 3'd1, S_RD = 3'd2, S_WR = 3'd3,
                         S_SRD = 3'd4, S_SWR = 3'd5, S_IGN = 3'd6, S_END = 3'd7;

  logic [1:0] sck_m, cs_m, si_m, hold_m;
  logic       sck_d;
  logic [2:0] st;
  logic [3:0] cnt;
  logic [14:0] shf;
  logic [ADDR_W-1:0] addr;
  logic [7:0] tx;
  logic       tx_vld, held, is_rd;
  logic [1:0] mode;
  logic       hdis;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_m <= 2'b00; cs_m <= 2'b11; si_m <= 2'b00; hold_m <= 2'b11; sck_d <= 1'b0;
    end else begin
      sck_m <= {sck_m[0], sck}; cs_m <= {cs_m[0], cs_n};
      si_m <= {si_m[0], si}; hold_m <= {hold_m[0], hold_n}; sck_d <= sck_m[1];
    end

  wire sck_s  = sck_m[1];
  wire cs_s   = cs_m[1];
  wire si_s   = si_m[1];
  wire hold_s = hold_m[1];
  wire rise_act = sck_s & ~sck_d & ~cs_s & ~held;
  wire fall_act = ~sck_s & sck_d & ~cs_s & ~held;
  wire [15:0] word = {shf, si_s};
  wire [7:0] byte_in = word[7:0];
  wire last = (cnt == 4'd7);
  wire pg = (mode == 2'b10);
  wire sq = (mode == 2'b01);
  wire [ADDR_W-1:0] addr_nx = pg ? {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1}
                                 : addr + 1'b1;
  wire [7:0] status_b = {mode, 5'b00000, hdis};
  wire mem_we = rise_act && st == S_WR && last;

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_CMD; cnt <= '0; shf <= '0; addr <= '0; tx <= '0;
      tx_vld <= 1'b0; held <= 1'b0; is_rd <= 1'b0; mode <= 2'b00; hdis <= 1'b0;
    end else if (cs_s) begin
      st <= S_CMD; cnt <= '0; tx_vld <= 1'b0; held <= 1'b0;
    end else begin
      if (!held && !hdis && !hold_s && !sck_s) held <= 1'b1;
      else if (held && hold_s && !sck_s) held <= 1'b0;
      if (rise_act) begin
        shf <= word[14:0];
        cnt <= cnt + 4'd1;
        case (st)
          S_CMD: if (last) begin
            cnt <= '0;
            case (byte_in)
              8'h03: begin st <= S_ADR; is_rd <= 1'b1; end
              8'h02: begin st <= S_ADR; is_rd <= 1'b0; end
              8'h05: st <= S_SRD;
              8'h01: st <= S_SWR;
              default: st <= S_IGN;
            endcase
          end
          S_ADR: if (cnt == 4'd15) begin
            cnt <= '0;
            addr <= word[ADDR_W-1:0];
            st <= is_rd ? S_RD : S_WR;
          end
          S_RD, S_WR: if (last) begin
            cnt <= '0;
            addr <= addr_nx;
            if (!pg && !sq) begin st <= S_END; tx_vld <= 1'b0; end
          end
          S_SWR: if (last) begin
            mode <= byte_in[7:6]; hdis <= byte_in[0]; st <= S_END;
          end
          S_SRD: if (last) begin st <= S_END; tx_vld <= 1'b0; end
          default: ;
        endcase
      end
      if (fall_act && (st == S_RD || st == S_SRD)) begin
        tx_vld <= 1'b1;
        if (cnt == 4'd0) tx <= (st == S_RD) ? mem[addr] : status_b;
        else tx <= {tx[6:0], 1'b0};
      end
    end

  assign so    = tx[7];
  assign so_oe = ~cs_s & ~held & tx_vld;
endmodule

module spi_sram_target_chk #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic held,
  input logic fall_act,
  input logic so_oe,
  input logic [2:0] st,
  input logic [3:0] cnt,
  input logic [1:0] mode,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [2:0] C_CMD = 3'd0, C_RD = 3'd2, C_WR = 3'd3;
  wire data_st = (st == C_RD) || (st == C_WR);

  a_r4_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> ($past(fall_act) || $fell(held)));

  a_r8_deselect_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> (st == C_CMD && !so_oe));

  a_r11_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(addr) && $stable(cnt) && $stable(st)));

  a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (data_st && $past(st) == st && mode == 2'b10 && $past(mode) == 2'b10)
      |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  a_r7_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_st && $past(st) == st && mode == 2'b01 && $past(mode) == 2'b01)
      |-> (addr == $past(addr) || addr == $past(addr) + 1'b1));
endmodule

bind spi_sram_target spi_sram_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .held(held), .fall_act(fall_act),
  .so_oe(so_oe), .st(st), .cnt(cnt), .mode(mode), .addr(addr)
);

// File: tb/test_spi_sram_target.sv
module test_spi_sram_target;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  int checks = 0, errors = 0, cs_hi = 0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] mstat = 8'h00;
  logic in_hold = 1'b0;

  always #2 clk = ~clk;

  spi_sram_target #(.ADDR_W(AW), .PAGE_W(5)) i_spi_sram_target (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cs_hi = cs_n ? cs_hi + 1 : 0;
    if (rst_n && cs_hi >= 4) chk(!so_oe, "R8 so_oe while deselected", so_oe, 0);
    if (rst_n && in_hold) chk(!so_oe, "R11 so_oe while held", so_oe, 0);
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r, output logic oe);
    si = b;
    wait_clk(HALF);
    r = so; oe = so_oe;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic bytex(input logic [7:0] t, output logic [7:0] r, output logic oe_all,
                       output logic oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic b, o;
      bitx(t[i], b, o);
      r[i] = b; oe_all &= o; oe_any |= o;
    end
  endtask

  task automatic begin_op(); cs_n = 1'b0; wait_clk(4); endtask
  task automatic end_op(); wait_clk(HALF); cs_n = 1'b1; wait_clk(8); endtask

  function automatic logic byte_mode();
    return !(mstat[7:6] == 2'b10 || mstat[7:6] == 2'b01);
  endfunction

  function automatic int nxt(input int a);
    if (mstat[7:6] == 2'b10) return (a & ~31) | ((a + 1) & 31);
    return (a + 1) % DEPTH;
  endfunction

  task automatic send_hdr(input logic [7:0] op, input logic [15:0] a, output logic oe_any);
    logic [7:0] r; logic oa, on;
    bytex(op, r, oa, on); oe_any = on;
    bytex(a[15:8], r, oa, on); oe_any |= on;
    bytex(a[7:0], r, oa, on); oe_any |= on;
  endtask

  task automatic write_op(input logic [15:0] a, input int n, input logic [7:0] seed);
    logic [7:0] r; logic oa, on, hdr;
    int ad = a % DEPTH;
    begin_op();
    send_hdr(8'h02, a, hdr);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed + 8'(k * 7);
      bytex(d, r, oa, on);
      if (k == 0 || !byte_mode()) begin mdl[ad] = d; ad = nxt(ad); end
    end
    end_op();
  endtask

  task automatic read_op(input logic [15:0] a, input int n, input string req);
    logic [7:0] r; logic oa, on, hdr;
    int ad = a % DEPTH;
    begin_op();
    send_hdr(8'h03, a, hdr);
    chk(!hdr, "R4 so_oe during opcode/address", hdr, 0);
    for (int k = 0; k < n; k++) begin
      bytex(8'h00, r, oa, on);
      if (k == 0 || !byte_mode()) begin
        chk(oa && r == mdl[ad], req, {oa, r}, {1'b1, mdl[ad]});
        ad = nxt(ad);
      end else chk(!on, "R5 so_oe after single byte", on, 0);
    end
    end_op();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r; logic oa, on;
    begin_op();
    bytex(8'h01, r, oa, on);
    bytex(v, r, oa, on);
    end_op();
    mstat = {v[7:6], 5'b0, v[0]};
  endtask

  task automatic rdsr(input string req);
    logic [7:0] r; logic oa, on;
    begin_op();
    bytex(8'h05, r, oa, on);
    bytex(8'h00, r, oa, on);
    end_op();
    chk(oa && r == mstat, req, {oa, r}, {1'b1, mstat});
  endtask

  initial begin
    logic [7:0] r; logic oa, on, hdr, b, o;
    wait_clk(5); rst_n = 1'b1; wait_clk(6);
    chk(!so_oe, "R1 so_oe after reset", so_oe, 0);
    rdsr("R1 status after reset");

    // sequential fill and readback
    wrsr(8'h40); rdsr("R9 status sequential");
    write_op(16'h0040, 8, 8'h20);
    read_op(16'h0040, 8, "R2 R7 sequential read");

    // single-byte mode
    wrsr(8'h00);
    write_op(16'h0040, 3, 8'h90);
    read_op(16'h0040, 3, "R5 single byte read");
    wrsr(8'h40);
    read_op(16'h0040, 3, "R5 neighbours unchanged");

    // page wrap
    wrsr(8'h80);
    write_op(16'h007E, 4, 8'h30);
    read_op(16'h007E, 4, "R6 page wrap read");
    wrsr(8'h40);
    read_op(16'h0040, 2, "R6 next page untouched");

    // sequential top wrap
    write_op(16'h03FE, 4, 8'h50);
    read_op(16'h03FE, 4, "R7 array wrap");
    write_op(16'h0200, 2, 8'hA0);

    // high address bits ignored
    write_op(16'hFD23, 1, 8'h6C);
    read_op(16'h0123, 1, "R3 upper address ignored");

    // reserved bits and reserved mode
    wrsr(8'hFF); rdsr("R9 reserved bits read zero");
    write_op(16'h0200, 2, 8'h11);
    wrsr(8'h40);
    read_op(16'h0200, 2, "R10 mode 11 single byte");

    // hold disabled
    wrsr(8'h41);
    hold_n = 1'b0;
    read_op(16'h0040, 2, "R12 hold ignored when disabled");
    hold_n = 1'b1;

    // hold during read
    wrsr(8'h40);
    begin_op();
    send_hdr(8'h03, 16'h0040, hdr);
    bytex(8'h00, r, oa, on);
    chk(oa && r == mdl[16'h40], "R11 read before hold", r, mdl[16'h40]);
    for (int i = 7; i >= 4; i--) begin bitx(1'b0, b, o); r[i] = b; end
    wait_clk(2); hold_n = 1'b0; wait_clk(4); in_hold = 1'b1;
    for (int i = 0; i < 5; i++) begin
      si = i[0]; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    in_hold = 1'b0; hold_n = 1'b1; wait_clk(4);
    for (int i = 3; i >= 0; i--) begin bitx(1'b0, b, o); r[i] = b; end
    end_op();
    chk(r == mdl[16'h41], "R11 read resumes after hold", r, mdl[16'h41]);

    // hold during write
    begin_op();
    send_hdr(8'h02, 16'h0045, hdr);
    for (int i = 7; i >= 5; i--) bitx(i[0], b, o);
    wait_clk(2); hold_n = 1'b0; wait_clk(4); in_hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      si = ~i[0]; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    in_hold = 1'b0; hold_n = 1'b1; wait_clk(4);
    for (int i = 4; i >= 0; i--) bitx(i[0], b, o);
    end_op();
    mdl[16'h45] = 8'b1010_1010;
    read_op(16'h0045, 1, "R11 SCK and SI ignored while held");

    // unknown opcode
    begin_op();
    send_hdr(8'h07, 16'h0040, hdr);
    bytex(8'h5A, r, oa, on); hdr |= on;
    bytex(8'hA5, r, oa, on); hdr |= on;
    end_op();
    chk(!hdr, "R13 so_oe after unknown opcode", hdr, 0);
    read_op(16'h0040, 1, "R13 memory unchanged");
    rdsr("R13 status unchanged");

    // abort mid-read
    begin_op();
    send_hdr(8'h03, 16'h0040, hdr);
    for (int i = 0; i < 4; i++) bitx(1'b0, b, o);
    end_op();
    rdsr("R8 new selection starts at opcode");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule